// File: doc/BRIEF.md
# Shared Ethernet MAC Stream Crossbar

This block lets one Ethernet MAC serve two packet consumers at once: a software-driven CPU port and a hardware protocol engine. On the receive side it takes the MAC's single packet stream and, frame by frame, sends each frame to the CPU, to the protocol engine, to both, or to neither. When filtering is off every frame goes to both. When filtering is on, the 48-bit destination address in the first word is compared against an address owned by each consumer. Broadcast and all-zero destinations are copied to both, so that either side can answer address-resolution traffic.

On the transmit side the two producers share the MAC's single transmit stream. Arbitration works on whole packets. A producer that raises valid while the path is idle is granted. It keeps the path until its last word has been accepted. If both producers ask in the same idle cycle, the grant alternates between them.

Every stream uses valid/ready/last with a data word and a byte-enable for the last word. The data word is at least 48 bits wide, and byte 0 of the frame sits in bits [7:0].

Top module: `eth_mac_xbar`

## Requirements
- R1: With `filter_en` low when a frame's first word arrives, every word of that frame is delivered to both receive consumers.
- R2: With filtering on, a frame whose destination (first-word bits [47:0]) equals `cpu_mac_addr` and is neither all ones nor all zeros goes to the CPU port only.
- R3: With filtering on, a frame whose destination equals `ip_mac_addr` and is neither all ones nor all zeros goes to the protocol-engine port only.
- R4: With filtering on, a frame whose destination is all ones (broadcast) or all zeros is delivered to both consumers.
- R5: With filtering on, a frame whose destination matches neither address and is neither all ones nor all zeros is dropped. `mac_rx_ready` stays high for that frame, and no consumer sees valid.
- R6: While a frame goes to both consumers, `mac_rx_ready` is the AND of both consumer readies. A consumer sees valid only when the other addressed consumer is also ready, so the two copies never drift apart.
- R7: The routing decision is taken on a frame's first word and held until its last word has been accepted. Changes to `filter_en` or to the addresses in the middle of a frame have no effect on that frame.
- R8: A producer that requests while the transmit path is idle is granted, and its words appear on the MAC transmit stream.
- R9: Once a producer is granted, the other producer's ready stays low until the granted packet's last word has been accepted. Packets never interleave on the MAC transmit stream.
- R10: When both producers request in the same idle cycle, the grant alternates. After reset the CPU wins the first such tie.
- R11: Data, last flag and byte-enable pass unchanged in both directions.
- R12: A producer's ready is high only when the MAC transmit ready is high. A word transfers only when valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_en | input | 1 | Enables address-based receive steering |
| cpu_mac_addr | input | 48 | CPU address, byte 0 in bits [7:0] |
| ip_mac_addr | input | 48 | Protocol-engine address, byte 0 in bits [7:0] |
| mac_rx_valid | input | 1 | MAC receive word valid |
| mac_rx_ready | output | 1 | Crossbar accepts MAC receive word |
| mac_rx_data | input | DATA_W | MAC receive data |
| mac_rx_last | input | 1 | Last word of received frame |
| mac_rx_be | input | DATA_W/8 | Byte-enable of last receive word |
| cpu_rx_valid | output | 1 | CPU receive word valid |
| cpu_rx_ready | input | 1 | CPU accepts receive word |
| cpu_rx_data | output | DATA_W | CPU receive data |
| cpu_rx_last | output | 1 | CPU receive last flag |
| cpu_rx_be | output | DATA_W/8 | CPU receive byte-enable |
| ip_rx_valid | output | 1 | Engine receive word valid |
| ip_rx_ready | input | 1 | Engine accepts receive word |
| ip_rx_data | output | DATA_W | Engine receive data |
| ip_rx_last | output | 1 | Engine receive last flag |
| ip_rx_be | output | DATA_W/8 | Engine receive byte-enable |
| cpu_tx_valid | input | 1 | CPU transmit word valid |
| cpu_tx_ready | output | 1 | CPU transmit word accepted |
| cpu_tx_data | input | DATA_W | CPU transmit data |
| cpu_tx_last | input | 1 | CPU transmit last flag |
| cpu_tx_be | input | DATA_W/8 | CPU transmit byte-enable |
| ip_tx_valid | input | 1 | Engine transmit word valid |
| ip_tx_ready | output | 1 | Engine transmit word accepted |
| ip_tx_data | input | DATA_W | Engine transmit data |
| ip_tx_last | input | 1 | Engine transmit last flag |
| ip_tx_be | input | DATA_W/8 | Engine transmit byte-enable |
| mac_tx_valid | output | 1 | MAC transmit word valid |
| mac_tx_ready | input | 1 | MAC accepts transmit word |
| mac_tx_data | output | DATA_W | MAC transmit data |
| mac_tx_last | output | 1 | MAC transmit last flag |
| mac_tx_be | output | DATA_W/8 | MAC transmit byte-enable |

## Verification
Two conditions are hard to reach from the ports. The first is a tie on the transmit side: both producers must already be holding valid in the very idle cycle after a packet ends. The bench runs two producer threads in parallel, each with back-to-back packets, while the MAC ready toggles every cycle. Each producer therefore always has its next packet waiting when the other finishes. The second condition is a routing change in the middle of a frame. The bench accepts only the first word of a frame, then turns filtering off and rewrites the matched address before sending the remaining words.

// File: rtl/eth_xbar_pkg.sv
package eth_xbar_pkg;

    localparam int unsigned MAC_ADDR_W = 48;

    // Bit 0 selects the CPU consumer, bit 1 the protocol engine.
    typedef enum logic [1:0] {
        DST_NONE = 2'b00,
        DST_CPU  = 2'b01,
        DST_IP   = 2'b10,
        DST_BOTH = 2'b11
    } dst_e;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_IP  = 1'b1
    } src_e;

    typedef struct packed {
        logic active;
        dst_e dst;
    } rx_state_t;

    typedef struct packed {
        logic busy;
        src_e owner;
        src_e last_won;
    } tx_state_t;

endpackage

// File: rtl/eth_dst_classify.sv
module eth_dst_classify
    import eth_xbar_pkg::*;
(
    input  logic                  filter_en,
    input  logic [MAC_ADDR_W-1:0] dst_addr,
    input  logic [MAC_ADDR_W-1:0] cpu_addr,
    input  logic [MAC_ADDR_W-1:0] ip_addr,
    output dst_e                  dst
);

    logic is_bcast;
    logic is_zero;
    logic cpu_hit;
    logic ip_hit;

    always_comb begin
        is_bcast = &dst_addr;
        is_zero  = ~|dst_addr;
        cpu_hit  = (dst_addr == cpu_addr);
        ip_hit   = (dst_addr == ip_addr);
        if (!filter_en || is_bcast || is_zero) begin
            dst = DST_BOTH;
        end else begin
            dst = dst_e'({ip_hit, cpu_hit});
        end
    end

endmodule

// File: rtl/eth_rx_steer.sv
module eth_rx_steer
    import eth_xbar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  filter_en,
    input  logic [MAC_ADDR_W-1:0] cpu_addr,
    input  logic [MAC_ADDR_W-1:0] ip_addr,
    input  logic                  in_valid,
    input  logic [MAC_ADDR_W-1:0] in_addr,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic [1:0]            out_valid,
    input  logic [1:0]            out_ready
);

    rx_state_t st_q, st_d;
    dst_e      dst_new;
    logic [1:0] want;
    logic      xfer;

    eth_dst_classify u_classify (
        .filter_en (filter_en),
        .dst_addr  (in_addr),
        .cpu_addr  (cpu_addr),
        .ip_addr   (ip_addr),
        .dst       (dst_new)
    );

    always_comb begin
        st_d     = st_q;
        want     = st_q.active ? st_q.dst : dst_new;
        in_ready = (!want[0] || out_ready[0]) && (!want[1] || out_ready[1]);
        xfer     = in_valid && in_ready;
        if (xfer) begin
            st_d.active = !in_last;
            st_d.dst    = dst_e'(want);
        end
    end

    // A consumer only sees valid when every other addressed consumer can take the word too.
    for (genvar i = 0; i < 2; i++) begin : g_cons
        assign out_valid[i] = in_valid && want[i] && (!want[1-i] || out_ready[1-i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, dst: DST_NONE};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/eth_tx_arbiter.sv
module eth_tx_arbiter
    import eth_xbar_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned BE_W   = DATA_W / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 in_valid,
    output logic [1:0]                 in_ready,
    input  logic [1:0][DATA_W-1:0]     in_data,
    input  logic [1:0]                 in_last,
    input  logic [1:0][BE_W-1:0]       in_be,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_last,
    output logic [BE_W-1:0]            out_be
);

    tx_state_t st_q, st_d;
    src_e      pick;
    logic      sel;
    logic      done;

    always_comb begin
        st_d = st_q;
        if (&in_valid) begin
            pick = (st_q.last_won == SRC_CPU) ? SRC_IP : SRC_CPU;
        end else if (in_valid[1]) begin
            pick = SRC_IP;
        end else begin
            pick = SRC_CPU;
        end
        sel       = st_q.busy ? st_q.owner : pick;
        out_valid = in_valid[sel];
        out_data  = in_data[sel];
        out_last  = in_last[sel];
        out_be    = in_be[sel];
        done      = out_valid && out_ready && out_last;
        if (!st_q.busy && |in_valid) begin
            st_d.owner    = pick;
            st_d.last_won = pick;
            st_d.busy     = !done;
        end else if (st_q.busy && done) begin
            st_d.busy = 1'b0;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_prod
        assign in_ready[i] = out_ready && (sel == 1'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, owner: SRC_CPU, last_won: SRC_IP};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/eth_mac_xbar.sv
module eth_mac_xbar
    import eth_xbar_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  filter_en,
    input  logic [MAC_ADDR_W-1:0] cpu_mac_addr,
    input  logic [MAC_ADDR_W-1:0] ip_mac_addr,
    input  logic                  mac_rx_valid,
    output logic                  mac_rx_ready,
    input  logic [DATA_W-1:0]     mac_rx_data,
    input  logic                  mac_rx_last,
    input  logic [BE_W-1:0]       mac_rx_be,
    output logic                  cpu_rx_valid,
    input  logic                  cpu_rx_ready,
    output logic [DATA_W-1:0]     cpu_rx_data,
    output logic                  cpu_rx_last,
    output logic [BE_W-1:0]       cpu_rx_be,
    output logic                  ip_rx_valid,
    input  logic                  ip_rx_ready,
    output logic [DATA_W-1:0]     ip_rx_data,
    output logic                  ip_rx_last,
    output logic [BE_W-1:0]       ip_rx_be,
    input  logic                  cpu_tx_valid,
    output logic                  cpu_tx_ready,
    input  logic [DATA_W-1:0]     cpu_tx_data,
    input  logic                  cpu_tx_last,
    input  logic [BE_W-1:0]       cpu_tx_be,
    input  logic                  ip_tx_valid,
    output logic                  ip_tx_ready,
    input  logic [DATA_W-1:0]     ip_tx_data,
    input  logic                  ip_tx_last,
    input  logic [BE_W-1:0]       ip_tx_be,
    output logic                  mac_tx_valid,
    input  logic                  mac_tx_ready,
    output logic [DATA_W-1:0]     mac_tx_data,
    output logic                  mac_tx_last,
    output logic [BE_W-1:0]       mac_tx_be
);

    logic [1:0] rx_valid_vec;
    logic [1:0] tx_ready_vec;

    eth_rx_steer u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .filter_en (filter_en),
        .cpu_addr  (cpu_mac_addr),
        .ip_addr   (ip_mac_addr),
        .in_valid  (mac_rx_valid),
        .in_addr   (mac_rx_data[MAC_ADDR_W-1:0]),
        .in_last   (mac_rx_last),
        .in_ready  (mac_rx_ready),
        .out_valid (rx_valid_vec),
        .out_ready ({ip_rx_ready, cpu_rx_ready})
    );

    assign cpu_rx_valid = rx_valid_vec[0];
    assign ip_rx_valid  = rx_valid_vec[1];
    assign cpu_rx_data  = mac_rx_data;
    assign ip_rx_data   = mac_rx_data;
    assign cpu_rx_last  = mac_rx_last;
    assign ip_rx_last   = mac_rx_last;
    assign cpu_rx_be    = mac_rx_be;
    assign ip_rx_be     = mac_rx_be;

    eth_tx_arbiter #(
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  ({ip_tx_valid, cpu_tx_valid}),
        .in_ready  (tx_ready_vec),
        .in_data   ({ip_tx_data, cpu_tx_data}),
        .in_last   ({ip_tx_last, cpu_tx_last}),
        .in_be     ({ip_tx_be, cpu_tx_be}),
        .out_valid (mac_tx_valid),
        .out_ready (mac_tx_ready),
        .out_data  (mac_tx_data),
        .out_last  (mac_tx_last),
        .out_be    (mac_tx_be)
    );

    assign cpu_tx_ready = tx_ready_vec[0];
    assign ip_tx_ready  = tx_ready_vec[1];

endmodule

// File: rtl/eth_mac_xbar_chk.sv
module eth_mac_xbar_chk #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mac_rx_valid,
    input logic              mac_rx_ready,
    input logic              cpu_rx_valid,
    input logic              cpu_rx_ready,
    input logic              ip_rx_valid,
    input logic              ip_rx_ready,
    input logic              cpu_tx_valid,
    input logic              cpu_tx_ready,
    input logic [DATA_W-1:0] cpu_tx_data,
    input logic              cpu_tx_last,
    input logic [BE_W-1:0]   cpu_tx_be,
    input logic              ip_tx_valid,
    input logic              ip_tx_ready,
    input logic              ip_tx_last,
    input logic              mac_tx_valid,
    input logic              mac_tx_ready,
    input logic [DATA_W-1:0] mac_tx_data,
    input logic              mac_tx_last,
    input logic [BE_W-1:0]   mac_tx_be
);

    logic cpu_open_q;
    logic ip_open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_open_q <= 1'b0;
            ip_open_q  <= 1'b0;
        end else begin
            if (cpu_tx_valid && cpu_tx_ready) cpu_open_q <= !cpu_tx_last;
            if (ip_tx_valid && ip_tx_ready)   ip_open_q  <= !ip_tx_last;
        end
    end

    p_cpu_no_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rx_valid && mac_rx_ready && cpu_rx_valid |-> cpu_rx_ready);
    p_ip_no_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rx_valid && mac_rx_ready && ip_rx_valid |-> ip_rx_ready);
    p_cpu_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rx_valid && cpu_rx_ready |-> mac_rx_valid && mac_rx_ready);
    p_ip_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ip_rx_valid && ip_rx_ready |-> mac_rx_valid && mac_rx_ready);
    p_hold_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_open_q |-> !ip_tx_ready);
    p_hold_ip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ip_open_q |-> !cpu_tx_ready);
    p_pass_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tx_valid && cpu_tx_ready |->
            mac_tx_valid && mac_tx_data == cpu_tx_data &&
            mac_tx_last == cpu_tx_last && mac_tx_be == cpu_tx_be);
    p_ready_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tx_ready || ip_tx_ready) |-> mac_tx_ready);
    p_no_idle_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mac_tx_valid |-> (cpu_tx_valid || ip_tx_valid));

endmodule

bind eth_mac_xbar eth_mac_xbar_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mac_rx_valid (mac_rx_valid),
    .mac_rx_ready (mac_rx_ready),
    .cpu_rx_valid (cpu_rx_valid),
    .cpu_rx_ready (cpu_rx_ready),
    .ip_rx_valid  (ip_rx_valid),
    .ip_rx_ready  (ip_rx_ready),
    .cpu_tx_valid (cpu_tx_valid),
    .cpu_tx_ready (cpu_tx_ready),
    .cpu_tx_data  (cpu_tx_data),
    .cpu_tx_last  (cpu_tx_last),
    .cpu_tx_be    (cpu_tx_be),
    .ip_tx_valid  (ip_tx_valid),
    .ip_tx_ready  (ip_tx_ready),
    .ip_tx_last   (ip_tx_last),
    .mac_tx_valid (mac_tx_valid),
    .mac_tx_ready (mac_tx_ready),
    .mac_tx_data  (mac_tx_data),
    .mac_tx_last  (mac_tx_last),
    .mac_tx_be    (mac_tx_be)
);

// File: tb/eth_mac_xbar_tb.sv
module eth_mac_xbar_tb_top;

    localparam int DW = 64;
    localparam int BW = DW / 8;
    localparam logic [47:0] CPU_A = 48'h0A_11_22_33_44_02;
    localparam logic [47:0] IP_A  = 48'h0A_11_22_33_44_03;

    typedef struct packed {
        logic        filt;
        logic [47:0] dst;
        logic        exp_cpu;
        logic        exp_ip;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{1'b0, CPU_A,           1'b1, 1'b1},
        '{1'b0, 48'h0C_DE_AD_00_77_01, 1'b1, 1'b1},
        '{1'b1, CPU_A,           1'b1, 1'b0},
        '{1'b1, IP_A,            1'b0, 1'b1},
        '{1'b1, 48'hFF_FF_FF_FF_FF_FF, 1'b1, 1'b1},
        '{1'b1, 48'h0,           1'b1, 1'b1},
        '{1'b1, 48'h0C_DE_AD_00_77_01, 1'b0, 1'b0},
        '{1'b1, IP_A,            1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic filter_en = 1'b0;
    logic [47:0] cpu_mac_addr = CPU_A;
    logic [47:0] ip_mac_addr = IP_A;
    logic mac_rx_valid = 1'b0, mac_rx_last = 1'b0;
    logic [DW-1:0] mac_rx_data = '0;
    logic [BW-1:0] mac_rx_be = '0;
    logic mac_rx_ready;
    logic cpu_rx_valid, cpu_rx_last, ip_rx_valid, ip_rx_last;
    logic [DW-1:0] cpu_rx_data, ip_rx_data;
    logic [BW-1:0] cpu_rx_be, ip_rx_be;
    logic cpu_rx_ready = 1'b1, ip_rx_ready = 1'b1;
    logic cpu_tx_valid = 1'b0, cpu_tx_last = 1'b0, ip_tx_valid = 1'b0, ip_tx_last = 1'b0;
    logic [DW-1:0] cpu_tx_data = '0, ip_tx_data = '0;
    logic [BW-1:0] cpu_tx_be = '0, ip_tx_be = '0;
    logic cpu_tx_ready, ip_tx_ready;
    logic mac_tx_valid, mac_tx_last;
    logic [DW-1:0] mac_tx_data;
    logic [BW-1:0] mac_tx_be;
    logic mac_tx_ready = 1'b1;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    eth_mac_xbar #(.DATA_W(DW)) dut_i (.*);

    // Port monitors.
    logic clr = 1'b0;
    int cpu_cnt, ip_cnt, tx_cnt, interleave, nstart;
    logic [DW-1:0] cpu_last_data, tx_last_data;
    logic [BW-1:0] cpu_last_be, tx_last_be;
    logic [3:0] starts [0:7];
    logic [3:0] cur_tag;
    logic prev_last;

    always @(posedge clk) begin
        if (clr) begin
            cpu_cnt = 0; ip_cnt = 0; tx_cnt = 0; interleave = 0; nstart = 0;
            prev_last = 1'b1; cur_tag = 4'h0;
        end else begin
            if (cpu_rx_valid && cpu_rx_ready) begin
                cpu_cnt++;
                cpu_last_data = cpu_rx_data;
                cpu_last_be = cpu_rx_be;
            end
            if (ip_rx_valid && ip_rx_ready) ip_cnt++;
            if (mac_tx_valid && mac_tx_ready) begin
                tx_cnt++;
                if (!prev_last && mac_tx_data[63:60] != cur_tag) interleave++;
                if (prev_last && nstart < 8) begin
                    starts[nstart] = mac_tx_data[63:60];
                    nstart++;
                end
                cur_tag = mac_tx_data[63:60];
                prev_last = mac_tx_last;
                tx_last_data = mac_tx_data;
                tx_last_be = mac_tx_be;
            end
        end
    end

    // MAC transmit ready pattern.
    logic tx_throttle = 1'b0, tx_hold = 1'b0, tx_phase = 1'b0;
    always @(negedge clk) begin
        tx_phase = ~tx_phase;
        mac_tx_ready = tx_hold ? 1'b0 : (tx_throttle ? tx_phase : 1'b1);
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    function automatic logic [DW-1:0] rx_word(input logic [47:0] dst, input int k);
        if (k == 0) return {16'hBEEF, dst};
        return 64'hD000_0000_0000_0000 | 64'(k);
    endfunction

    task automatic send_rx(input logic [47:0] dst, input int n, input logic [BW-1:0] lbe);
        for (int k = 0; k < n; k++) begin
            mac_rx_valid = 1'b1;
            mac_rx_data = rx_word(dst, k);
            mac_rx_last = (k == n - 1);
            mac_rx_be = (k == n - 1) ? lbe : '1;
            #1;
            while (!mac_rx_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        mac_rx_valid = 1'b0;
        mac_rx_last = 1'b0;
    endtask

    task automatic send_cpu_tx(input int pkts, input int n, input logic [BW-1:0] lbe);
        for (int p = 0; p < pkts; p++) begin
            for (int k = 0; k < n; k++) begin
                cpu_tx_valid = 1'b1;
                cpu_tx_data = {4'hC, 52'(p), 8'(k)};
                cpu_tx_last = (k == n - 1);
                cpu_tx_be = (k == n - 1) ? lbe : '1;
                #1;
                while (!cpu_tx_ready) begin @(negedge clk); #1; end
                @(negedge clk);
            end
        end
        cpu_tx_valid = 1'b0;
        cpu_tx_last = 1'b0;
    endtask

    task automatic send_ip_tx(input int pkts, input int n, input logic [BW-1:0] lbe);
        for (int p = 0; p < pkts; p++) begin
            for (int k = 0; k < n; k++) begin
                ip_tx_valid = 1'b1;
                ip_tx_data = {4'hA, 52'(p), 8'(k)};
                ip_tx_last = (k == n - 1);
                ip_tx_be = (k == n - 1) ? lbe : '1;
                #1;
                while (!ip_tx_ready) begin @(negedge clk); #1; end
                @(negedge clk);
            end
        end
        ip_tx_valid = 1'b0;
        ip_tx_last = 1'b0;
    endtask

    function automatic string vec_req(input vec_t v);
        if (!v.filt) return "R1";
        if (v.exp_cpu && v.exp_ip) return "R4";
        if (v.exp_cpu) return "R2";
        if (v.exp_ip) return "R3";
        return "R5";
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_counts();

        // Reset state
        check(!mac_tx_valid, "R8 reset tx idle", 64'(mac_tx_valid), 64'h0);
        check(!cpu_rx_valid && !ip_rx_valid, "R1 reset rx idle", 64'({cpu_rx_valid, ip_rx_valid}), 64'h0);

        // Table walk: receive steering
        for (int i = 0; i < 8; i++) begin
            clear_counts();
            filter_en = VECS[i].filt;
            send_rx(VECS[i].dst, 2, 8'h3F);
            repeat (2) @(negedge clk);
            check(cpu_cnt == (VECS[i].exp_cpu ? 2 : 0), vec_req(VECS[i]),
                  64'(cpu_cnt), VECS[i].exp_cpu ? 64'd2 : 64'd0);
            check(ip_cnt == (VECS[i].exp_ip ? 2 : 0), vec_req(VECS[i]),
                  64'(ip_cnt), VECS[i].exp_ip ? 64'd2 : 64'd0);
            if (VECS[i].exp_cpu) begin
                check(cpu_last_be == 8'h3F && cpu_last_data == rx_word(VECS[i].dst, 1),
                      "R11 rx pass", cpu_last_data, rx_word(VECS[i].dst, 1));
            end
        end

        // R6: one consumer stalls a dual-delivery frame
        clear_counts();
        filter_en = 1'b0;
        ip_rx_ready = 1'b0;
        mac_rx_valid = 1'b1;
        mac_rx_data = rx_word(CPU_A, 0);
        mac_rx_last = 1'b0;
        #1;
        check(!mac_rx_ready, "R6 mac ready low", 64'(mac_rx_ready), 64'h0);
        check(!cpu_rx_valid, "R6 cpu valid gated", 64'(cpu_rx_valid), 64'h0);
        repeat (2) @(negedge clk);
        check(cpu_cnt == 0, "R6 no early cpu word", 64'(cpu_cnt), 64'h0);
        ip_rx_ready = 1'b1;
        send_rx(CPU_A, 2, 8'h01);
        repeat (2) @(negedge clk);
        check(cpu_cnt == 2 && ip_cnt == 2, "R6 both copies",
              64'({cpu_cnt[15:0], ip_cnt[15:0]}), 64'h0002_0002);

        // R7: decision held while filter and address change mid-frame
        clear_counts();
        filter_en = 1'b1;
        mac_rx_valid = 1'b1;
        mac_rx_data = rx_word(CPU_A, 0);
        mac_rx_last = 1'b0;
        #1;
        while (!mac_rx_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        filter_en = 1'b0;
        cpu_mac_addr = 48'h0A_99_99_99_99_99;
        for (int k = 1; k < 3; k++) begin
            mac_rx_data = rx_word(CPU_A, k);
            mac_rx_last = (k == 2);
            mac_rx_be = 8'h0F;
            #1;
            while (!mac_rx_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        mac_rx_valid = 1'b0;
        mac_rx_last = 1'b0;
        repeat (2) @(negedge clk);
        check(cpu_cnt == 3, "R7 cpu keeps frame", 64'(cpu_cnt), 64'd3);
        check(ip_cnt == 0, "R7 ip unaffected", 64'(ip_cnt), 64'd0);
        cpu_mac_addr = CPU_A;

        // R8 / R11: single producers
        clear_counts();
        send_cpu_tx(1, 3, 8'h07);
        repeat (2) @(negedge clk);
        check(tx_cnt == 3 && starts[0] == 4'hC, "R8 cpu alone", 64'(tx_cnt), 64'd3);
        check(tx_last_be == 8'h07 && tx_last_data == {4'hC, 52'd0, 8'd2},
              "R11 tx pass", tx_last_data, {4'hC, 52'd0, 8'd2});
        clear_counts();
        send_ip_tx(1, 2, 8'h03);
        repeat (2) @(negedge clk);
        check(tx_cnt == 2 && starts[0] == 4'hA, "R8 ip alone", 64'(tx_cnt), 64'd2);

        // R9 / R10 / R12: both producers contend under a throttled MAC
        clear_counts();
        tx_throttle = 1'b1;
        fork
            send_cpu_tx(2, 3, 8'hFF);
            send_ip_tx(2, 3, 8'hFF);
        join
        tx_throttle = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_cnt == 12, "R12 word count", 64'(tx_cnt), 64'd12);
        check(interleave == 0, "R9 no interleave", 64'(interleave), 64'd0);
        check(nstart == 4, "R10 packet count", 64'(nstart), 64'd4);
        check({starts[0], starts[1], starts[2], starts[3]} == 16'hCACA, "R10 alternation",
              64'({starts[0], starts[1], starts[2], starts[3]}), 64'hCACA);

        // R12: MAC stalled, producer held off
        clear_counts();
        tx_hold = 1'b1;
        @(negedge clk);
        cpu_tx_valid = 1'b1;
        cpu_tx_data = {4'hC, 60'h5};
        cpu_tx_last = 1'b1;
        cpu_tx_be = 8'h01;
        #1;
        check(mac_tx_valid && !cpu_tx_ready && !ip_tx_ready, "R12 stall ready",
              64'({mac_tx_valid, cpu_tx_ready, ip_tx_ready}), 64'h4);
        repeat (2) @(negedge clk);
        check(tx_cnt == 0, "R12 no transfer", 64'(tx_cnt), 64'd0);
        tx_hold = 1'b0;
        #1;
        while (!cpu_tx_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cpu_tx_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_cnt == 1, "R12 released", 64'(tx_cnt), 64'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule